// File: doc/BRIEF.md
# Pin Interrupt Aggregator with End-of-Service Handshake

This block sits between a bank of per-pin interrupt detectors and the core's interrupt input. It folds the pending flags of up to 184 pins into a compact summary in which every bit stands for a group of four neighbouring pins. Software reads that summary as two 32-bit status words and then visits only the groups that are flagged. A single level-type interrupt line goes to the core. Software ends its service routine by writing an end-of-service bit in a control register. The line then drops for one cycle and comes back if anything is still pending.

The control register also has a settle-window feature. When its hold-enable bit is set, any debounce configuration write to any pin starts a window of programmable length, counted in slow-clock ticks. During the window the block hides status for every pin. The summary reads as zero, the interrupt line stays low, and the per-pin interrupt-enable view that the block passes on reads as zero. Polling software can use that enable view to tell when the window has ended.

Top module: `pin_irq_aggregator`

## Requirements
- R1: Summary bit g is the OR of pending flags of pins 4g, 4g+1, 4g+2 and 4g+3, for g from 0 to 45. Status word address 0 carries summary bits 31..0. Status word address 1 carries summary bits 45..32 in its bits 13..0.
- R2: Bits 31..14 of status word address 1 always read 0. These are summary bits 46..63.
- R3: The control register is at address 2. Its bits 11..0 hold the window length, and bit 12 holds the hold-enable. Both read back as written, and both are 0 after reset. A read returns data in the same cycle, and a write is visible from the next cycle.
- R4: Bit 13 of the control register is the end-of-service bit. It never stores a value and always reads 0.
- R5: irq_o is high in the cycle after any summary bit is set, and low in the cycle after no summary bit is set.
- R6: A control write with bit 13 set drives irq_o low in the following cycle. irq_o then re-asserts in the next cycle if any summary bit is still set.
- R7: With hold-enable set and a nonzero length L, a pulse on dbcfg_wr_i opens a window that lasts until L tick_i pulses have been counted. During the window both status words read 0, pin_en_o reads all zeros, and irq_o is low.
- R8: A dbcfg_wr_i pulse during an open window reloads the count to the full length.
- R9: With hold-enable clear, dbcfg_wr_i has no effect. Status and pin_en_o keep following their inputs.
- R10: With hold-enable set and a length of 0, dbcfg_wr_i opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 184 | Per-pin pending flags from the detectors |
| pin_en_i | input | 184 | Per-pin interrupt-enable bits as stored |
| pin_en_o | output | 184 | Enable view for software, forced to 0 during a settle window |
| dbcfg_wr_i | input | 1 | Strobe: a debounce configuration write to some pin |
| tick_i | input | 1 | One-cycle pulse from the slow time base |
| reg_addr_i | input | 2 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Shared interrupt line to the core |

## Verification
The in-line assertions check the following on every cycle:
- the interrupt line drops right after an end-of-service write,
- it is never high without pending status in the prior cycle,
- it stays low while a window is open,
- the enable view is blanked during a window,
- the end-of-service bit reads 0,
- the window count reloads on each arming strobe and never grows otherwise.

Only the bench scenarios can show the following:
- the exact mapping of every pin onto its summary bit and word,
- the exact window length in ticks and its restart,
- re-assertion after end of service,
- the cases where hold-enable is off or the length is zero.

// File: rtl/pinsum_pkg.sv
package pinsum_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT_LO = 2'd0,
    ADDR_STAT_HI = 2'd1,
    ADDR_CTRL    = 2'd2
  } pinsum_addr_e;

  localparam int LEN_W     = 12;
  localparam int HOLD_BIT  = 12;
  localparam int EOS_BIT   = 13;
  localparam int WORD_W    = 32;
endpackage

// File: rtl/pinsum_group_or.sv
module pinsum_group_or #(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  localparam int NGRP    = (NUM_PINS + GRP - 1) / GRP
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NGRP-1:0]     sum_o
);
  localparam int PAD = NGRP * GRP;

  logic [PAD-1:0] padded;
  assign padded = PAD'(pend_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign sum_o[g] = |padded[g*GRP +: GRP];
  end
endmodule

// File: rtl/pinsum_window.sv
module pinsum_window #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic             active_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (arm_i) begin
      cnt_en = 1'b1;
      cnt_d  = len_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  AST_ARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (cnt_q == $past(len_i))); // R8
  AST_COUNT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (cnt_q <= $past(cnt_q))); // R7
endmodule

// File: rtl/pinsum_irq_line.sv
module pinsum_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  input  logic eos_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = any_i && !eos_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_EOS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eos_i |=> !irq_o); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(any_i)); // R5
endmodule

// File: rtl/pin_irq_aggregator.sv
module pin_irq_aggregator
  import pinsum_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  output logic [NUM_PINS-1:0] pin_en_o,
  input  logic                dbcfg_wr_i,
  input  logic                tick_i,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_o
);
  localparam int NGRP = (NUM_PINS + GRP - 1) / GRP;
  localparam int WIDE = 2 * WORD_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // control register
  logic [LEN_W-1:0] len_q, len_d;
  logic             hold_q, hold_d;
  logic             wr_ctrl, eos_wr;

  always_comb begin
    wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    eos_wr  = wr_ctrl && reg_wdata_i[EOS_BIT];
    len_d   = reg_wdata_i[LEN_W-1:0];
    hold_d  = reg_wdata_i[HOLD_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      len_q  <= '0;
      hold_q <= 1'b0;
    end else if (wr_ctrl) begin
      len_q  <= len_d;
      hold_q <= hold_d;
    end
  end

  // settle window
  logic win_active;
  pinsum_window #(.LEN_W(LEN_W)) i_window (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm_i    (dbcfg_wr_i && hold_q),
    .len_i    (len_q),
    .tick_i   (tick_i),
    .active_o (win_active)
  );

  // summary
  logic [NUM_PINS-1:0] pend_vis;
  logic [NGRP-1:0]     sum_vec;
  logic [WIDE-1:0]     sum_wide;

  assign pend_vis = win_active ? '0 : pend_i;
  assign pin_en_o = win_active ? '0 : pin_en_i;

  pinsum_group_or #(.NUM_PINS(NUM_PINS), .GRP(GRP)) i_group (
    .pend_i (pend_vis),
    .sum_o  (sum_vec)
  );
  assign sum_wide = WIDE'(sum_vec);

  pinsum_irq_line i_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .any_i (|sum_vec),
    .eos_i (eos_wr),
    .irq_o (irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_STAT_LO: reg_rdata_o = sum_wide[WORD_W-1:0];
      ADDR_STAT_HI: reg_rdata_o = sum_wide[WIDE-1:WORD_W];
      ADDR_CTRL: begin
        reg_rdata_o[LEN_W-1:0] = len_q;
        reg_rdata_o[HOLD_BIT]  = hold_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[31:EOS_BIT+1];

  AST_EOS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr_i == ADDR_CTRL) |-> !reg_rdata_o[EOS_BIT]); // R4
  AST_WINDOW_HIDES_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_active |-> (pin_en_o == '0)); // R7
  AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_active |=> !irq_o); // R7
endmodule

// File: tb/test_pin_irq_aggregator.sv
module test_pin_irq_aggregator;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pend_i, pin_en_i, pin_en_o;
  logic          dbcfg_wr_i, tick_i, reg_wr_i, irq_o;
  logic [1:0]    reg_addr_i;
  logic [31:0]   reg_wdata_i, reg_rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pin_irq_aggregator i_pin_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .pin_en_i(pin_en_i),
    .pin_en_o(pin_en_o), .dbcfg_wr_i(dbcfg_wr_i), .tick_i(tick_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_sum(input logic [NP-1:0] p);
    logic [63:0] e = '0;
    for (int g = 0; g < NP/4; g++) e[g] = |p[4*g +: 4];
    return e;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_sum(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    s = {hi, lo};
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic pulse_cfg();
    @(negedge clk); dbcfg_wr_i = 1'b1;
    @(negedge clk); dbcfg_wr_i = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    logic [31:0] d;
    logic [NP-1:0] pat;
    rst_n = 1'b0; pend_i = '0; pin_en_i = '1; dbcfg_wr_i = 1'b0; tick_i = 1'b0;
    reg_wr_i = 1'b0; reg_addr_i = 2'd0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(irq_o == 1'b0, "R5 reset irq", irq_o, 0);
    rd(2'd2, d); chk(d == 32'h0, "R3 reset ctrl", d, 0);
    rd_sum(s);   chk(s == 64'h0, "R1 reset status", s, 0);

    // R1 R2 R5: sweep each single pin
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      pend_i = '0; pend_i[p] = 1'b1;
      rd_sum(s);
      chk(s == exp_sum(pend_i), "R1 single pin", s, exp_sum(pend_i));
      chk(s[63:46] == '0, "R2 upper zero", s[63:46], 0);
      @(negedge clk);
      chk(irq_o == 1'b1, "R5 irq on pending", irq_o, 1);
    end
    @(negedge clk); pend_i = '0;
    @(negedge clk);
    chk(irq_o == 1'b0, "R5 irq off", irq_o, 0);

    // R1 multi-pin patterns
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < NP; b++) pat[b] = (((b * (k + 3)) ^ (b >> (k % 3))) % (k + 5)) == 0;
      @(negedge clk); pend_i = pat;
      rd_sum(s);
      chk(s == exp_sum(pat), "R1 pattern", s, exp_sum(pat));
    end
    @(negedge clk); pend_i = '0;

    // R3 R4 control readback
    wr(2'd2, 32'h0000_1ABC);
    rd(2'd2, d); chk(d == 32'h1ABC, "R3 ctrl readback", d, 32'h1ABC);
    wr(2'd2, 32'h0000_3005);
    rd(2'd2, d); chk(d == 32'h1005, "R4 eos reads zero", d, 32'h1005);
    wr(2'd2, 32'h0000_0000);

    // R6 end-of-service handshake
    @(negedge clk); pend_i = '0; pend_i[77] = 1'b1;
    @(negedge clk);
    chk(irq_o == 1'b1, "R5 irq before eos", irq_o, 1);
    wr(2'd2, 32'h0000_2000);
    chk(irq_o == 1'b0, "R6 drop after eos", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R6 reassert", irq_o, 1);
    @(negedge clk); pend_i = '0;
    wr(2'd2, 32'h0000_2000);
    @(negedge clk);
    chk(irq_o == 1'b0, "R6 no reassert when idle", irq_o, 0);

    // R7 window of 3 ticks
    wr(2'd2, 32'h0000_1003);
    @(negedge clk); pend_i = '0; pend_i[150] = 1'b1;
    pulse_cfg();
    rd_sum(s); chk(s == 64'h0, "R7 status hidden", s, 0);
    chk(pin_en_o == '0, "R7 enable hidden", pin_en_o[63:0], 0);
    @(negedge clk);
    chk(irq_o == 1'b0, "R7 irq low", irq_o, 0);
    pulse_tick(); pulse_tick();
    rd_sum(s); chk(s == 64'h0, "R7 hidden after 2 ticks", s, 0);
    pulse_tick();
    rd_sum(s); chk(s == exp_sum(pend_i), "R7 visible after 3 ticks", s, exp_sum(pend_i));
    chk(pin_en_o == pin_en_i, "R7 enable back", pin_en_o[63:0], pin_en_i[63:0]);

    // R8 restart
    pulse_cfg();
    pulse_tick(); pulse_tick();
    pulse_cfg();
    pulse_tick(); pulse_tick();
    rd_sum(s); chk(s == 64'h0, "R8 restarted hidden", s, 0);
    pulse_tick();
    rd_sum(s); chk(s == exp_sum(pend_i), "R8 ends after full reload", s, exp_sum(pend_i));

    // R9 hold-enable off
    wr(2'd2, 32'h0000_0003);
    pulse_cfg();
    rd_sum(s); chk(s == exp_sum(pend_i), "R9 no window status", s, exp_sum(pend_i));
    chk(pin_en_o == pin_en_i, "R9 no window enable", pin_en_o[63:0], pin_en_i[63:0]);

    // R10 zero length
    wr(2'd2, 32'h0000_1000);
    pulse_cfg();
    rd_sum(s); chk(s == exp_sum(pend_i), "R10 zero length", s, exp_sum(pend_i));
    @(negedge clk);
    chk(irq_o == 1'b1, "R10 irq stays", irq_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule